// File: doc/BRIEF.md
# Reset Source Controller

This block sits beside a small microcontroller core and decides why the core is being reset. It watches an asynchronous power-on indication, a backup-battery comparator result, an external reset pin, a watchdog timeout pulse and a flag telling it the core is in its stop (oscillator-off) mode. From these it holds the core in reset for as long as the cause requires and loads the battery-backed control bits with a set of values chosen by the cause of the reset.

A power-on with a healthy battery leaves the control bits as the battery kept them. A power-on with a weak battery loads safe defaults. An external reset holds the core but touches none of the control bits. A watchdog reset holds the core for a fixed time and marks the power-on flag to show that this reset did not come from power. The control bits have no reset of their own. They model storage kept alive by the battery, so the first power-up of a system must be a weak-battery one to give them defined values.

Top module: `rstSourceCtrl`

## Requirements
- R1: When power-on completes with `battOk` low, the bits become porFlag=0, wdtEnable=0, partBits=4'b1111, rangeSel=1 (1 selects the 32K-byte space), encryptEn=0 and secLock=0.
- R2: When power-on completes with `battOk` high, every control bit keeps the value it had before power was removed.
- R3: `coreRst` is high while `porN` is low and falls at the third rising clock edge after `porN` goes high.
- R4: The external pin is taken through a two-stage synchronizer. A reset is accepted only after 24 consecutive high synchronized samples (two 12-clock machine cycles). A pin pulse spanning 23 rising edges causes no reset.
- R5: The pulse-width count restarts whenever the synchronized pin is low, so two 20-edge high bursts split by one low edge cause no reset.
- R6: An external reset leaves every control bit unchanged.
- R7: Once an external reset is accepted, `coreRst` stays high while the pin is high. Without stop mode it falls within three clocks after the pin goes low.
- R8: If `stopMode` was high when the external reset was accepted, `coreRst` stays high for a further `STAB_CLKS` clocks (65536 by default), counted from the release of the synchronized pin.
- R9: A one-clock `wdtTimeout` pulse during normal running holds `coreRst` high for exactly 24 clocks and sets porFlag to 1. It leaves the other bits unchanged.
- R10: If an external reset is accepted in the same clock as a watchdog timeout, the external reset wins. `coreRst` follows the pin and porFlag is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Power-on indication, low while power is not yet good (asynchronous) |
| battOk | input | 1 | Backup battery comparator, high when above minimum |
| extRstPin | input | 1 | External reset pin, active high, asynchronous |
| wdtTimeout | input | 1 | One-clock pulse when the watchdog expires |
| stopMode | input | 1 | High while the core is in stop mode |
| coreRst | output | 1 | Reset to the core, active high |
| porFlag | output | 1 | Power-on flag, 0 after a weak-battery power-on |
| wdtEnable | output | 1 | Watchdog enable bit |
| partBits | output | 4 | Memory partition address bits |
| rangeSel | output | 1 | Memory range select, 1 selects 32K bytes |
| encryptEn | output | 1 | Encryption enable |
| secLock | output | 1 | Security lock |

## Verification
An external reset can reach its 24-sample acceptance point in the same clock as a watchdog timeout pulse arrives. The bench holds the pin high and places the timeout pulse on the exact edge where acceptance happens. It then judges the outcome by porFlag, which must stay 0 because only a watchdog reset sets it, and by the reset length, which must track the pin and not the 24-clock watchdog hold.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_RUN,
    ST_EXT,
    ST_STAB,
    ST_WDT
  } rscState_t;

  typedef struct packed {
    logic applyPor;
    logic applyWdt;
    logic loadStab;
    logic loadWdt;
    logic latchStop;
    logic countDown;
  } rscStrobe_t;

  typedef struct packed {
    logic       porFlag;
    logic       wdtEnable;
    logic [3:0] partBits;
    logic       rangeSel;
    logic       encryptEn;
    logic       secLock;
  } rscBank_t;

  localparam rscBank_t BANK_SAFE = '{
    porFlag:   1'b0,
    wdtEnable: 1'b0,
    partBits:  4'hF,
    rangeSel:  1'b1,
    encryptEn: 1'b0,
    secLock:   1'b0
  };

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rsc_datapath.sv
module rsc_datapath
  import rsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EXT_MIN     = 24,
  parameter int STAB_CLKS   = 65536,
  parameter int WDT_CLKS    = 24
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       extRstPin,
  input  logic       stopMode,
  input  rscStrobe_t strb,
  output logic       porSync,
  output logic       rstHigh,
  output logic       extAccept,
  output logic       delayDone,
  output logic       stopLatched,
  output rscBank_t   bank
);

  localparam int PW      = $clog2(EXT_MIN + 1);
  localparam int DLY_MAX = (STAB_CLKS > WDT_CLKS) ? STAB_CLKS : WDT_CLKS;
  localparam int DW      = $clog2(DLY_MAX + 1);

  logic [PW-1:0] pulseCnt;
  logic [DW-1:0] delayCnt;

  rsc_sync #(.STAGES(SYNC_STAGES)) porSyncInst (
    .clk(clk), .arstN(porN), .d(1'b1), .q(porSync)
  );

  rsc_sync #(.STAGES(SYNC_STAGES)) pinSyncInst (
    .clk(clk), .arstN(porN), .d(extRstPin), .q(rstHigh)
  );

  // pulse-width counter: restarts on any low sample, saturates at the limit
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                          pulseCnt <= '0;
    else if (!rstHigh)                  pulseCnt <= '0;
    else if (pulseCnt != PW'(EXT_MIN))  pulseCnt <= pulseCnt + 1'b1;
  end

  assign extAccept = (pulseCnt == PW'(EXT_MIN));

  // shared hold-time counter for stabilization and watchdog holds
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                 delayCnt <= '0;
    else if (strb.loadStab)                    delayCnt <= DW'(STAB_CLKS - 1);
    else if (strb.loadWdt)                     delayCnt <= DW'(WDT_CLKS - 1);
    else if (strb.countDown && delayCnt != 0)  delayCnt <= delayCnt - 1'b1;
  end

  assign delayDone = (delayCnt == '0);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)               stopLatched <= 1'b0;
    else if (strb.latchStop) stopLatched <= stopMode;
  end

  // battery-backed bits: deliberately without reset
  always_ff @(posedge clk) begin
    if (strb.applyPor)      bank <= BANK_SAFE;
    else if (strb.applyWdt) bank.porFlag <= 1'b1;
  end

  // R4
  accept_width_chk: assert property (@(posedge clk) disable iff (!porN)
    extAccept |-> $past(rstHigh));

  // R1
  por_init_chk: assert property (@(posedge clk) disable iff (!porN)
    strb.applyPor |=> (bank.partBits == 4'hF && !bank.secLock &&
                       !bank.porFlag && !bank.wdtEnable && bank.rangeSel));

  // R9
  wdt_flag_chk: assert property (@(posedge clk) disable iff (!porN)
    strb.applyWdt |=> bank.porFlag);

endmodule

// File: rtl/rsc_control.sv
module rsc_control
  import rsc_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       porSync,
  input  logic       battOk,
  input  logic       rstHigh,
  input  logic       extAccept,
  input  logic       delayDone,
  input  logic       stopLatched,
  input  logic       wdtTimeout,
  output rscStrobe_t strb,
  output logic       coreRst
);

  rscState_t state, nextState;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_PWR;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_PWR: begin
        if (porSync) begin
          strb.applyPor = !battOk;
          nextState     = ST_RUN;
        end
      end
      ST_RUN: begin
        if (extAccept) begin
          strb.latchStop = 1'b1;
          nextState      = ST_EXT;
        end else if (wdtTimeout) begin
          strb.loadWdt  = 1'b1;
          strb.applyWdt = 1'b1;
          nextState     = ST_WDT;
        end
      end
      ST_EXT: begin
        if (!rstHigh) begin
          if (stopLatched) begin
            strb.loadStab = 1'b1;
            nextState     = ST_STAB;
          end else begin
            nextState = ST_RUN;
          end
        end
      end
      ST_STAB, ST_WDT: begin
        strb.countDown = 1'b1;
        if (extAccept) begin
          strb.latchStop = 1'b1;
          nextState      = ST_EXT;
        end else if (delayDone) begin
          nextState = ST_RUN;
        end
      end
      default: nextState = ST_PWR;
    endcase
  end

  assign coreRst = (state != ST_RUN);

  // R9
  wdt_entry_chk: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_RUN && wdtTimeout && !extAccept) |=> (state == ST_WDT && coreRst));

  // R10
  ext_priority_chk: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_RUN && extAccept) |=> (state == ST_EXT));

  // R8
  stop_delay_chk: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_EXT && !rstHigh && stopLatched) |=> (state == ST_STAB));

  // R7
  rst_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_EXT && rstHigh) |=> coreRst);

endmodule

// File: rtl/rstSourceCtrl.sv
module rstSourceCtrl
  import rsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MC_CLKS     = 12,
  parameter int EXT_MIN_MC  = 2,
  parameter int WDT_HOLD_MC = 2,
  parameter int STAB_CLKS   = 65536
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       battOk,
  input  logic       extRstPin,
  input  logic       wdtTimeout,
  input  logic       stopMode,
  output logic       coreRst,
  output logic       porFlag,
  output logic       wdtEnable,
  output logic [3:0] partBits,
  output logic       rangeSel,
  output logic       encryptEn,
  output logic       secLock
);

  localparam int EXT_MIN  = MC_CLKS * EXT_MIN_MC;
  localparam int WDT_CLKS = MC_CLKS * WDT_HOLD_MC;

  rscStrobe_t strb;
  rscBank_t   bank;
  logic       porSync, rstHigh, extAccept, delayDone, stopLatched;

  rsc_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .EXT_MIN    (EXT_MIN),
    .STAB_CLKS  (STAB_CLKS),
    .WDT_CLKS   (WDT_CLKS)
  ) dp (
    .clk        (clk),
    .porN       (porN),
    .extRstPin  (extRstPin),
    .stopMode   (stopMode),
    .strb       (strb),
    .porSync    (porSync),
    .rstHigh    (rstHigh),
    .extAccept  (extAccept),
    .delayDone  (delayDone),
    .stopLatched(stopLatched),
    .bank       (bank)
  );

  rsc_control ctl (
    .clk        (clk),
    .porN       (porN),
    .porSync    (porSync),
    .battOk     (battOk),
    .rstHigh    (rstHigh),
    .extAccept  (extAccept),
    .delayDone  (delayDone),
    .stopLatched(stopLatched),
    .wdtTimeout (wdtTimeout),
    .strb       (strb),
    .coreRst    (coreRst)
  );

  assign porFlag   = bank.porFlag;
  assign wdtEnable = bank.wdtEnable;
  assign partBits  = bank.partBits;
  assign rangeSel  = bank.rangeSel;
  assign encryptEn = bank.encryptEn;
  assign secLock   = bank.secLock;

endmodule

// File: tb/rstSourceCtrl_test.sv
`timescale 1ns/1ps
module rstSourceCtrl_test;

  localparam int STAB = 100;
  localparam logic [8:0] SAFE_BANK = 9'h07C;
  localparam logic [8:0] WDT_BANK  = 9'h17C;

  // {pulse length, stop mode, accept expected}
  localparam logic [9:0] VEC [6] = '{
    {8'd5,  1'b0, 1'b0},
    {8'd23, 1'b0, 1'b0},
    {8'd24, 1'b0, 1'b1},
    {8'd40, 1'b0, 1'b1},
    {8'd10, 1'b1, 1'b0},
    {8'd40, 1'b1, 1'b1}
  };

  logic clk = 0;
  logic porN = 0, battOk = 0, extRstPin = 0, wdtTimeout = 0, stopMode = 0;
  logic coreRst, porFlag, wdtEnable, rangeSel, encryptEn, secLock;
  logic [3:0] partBits;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rstSourceCtrl #(.STAB_CLKS(STAB)) uut (
    .clk(clk), .porN(porN), .battOk(battOk), .extRstPin(extRstPin),
    .wdtTimeout(wdtTimeout), .stopMode(stopMode), .coreRst(coreRst),
    .porFlag(porFlag), .wdtEnable(wdtEnable), .partBits(partBits),
    .rangeSel(rangeSel), .encryptEn(encryptEn), .secLock(secLock)
  );

  function automatic logic [8:0] bankNow();
    return {porFlag, wdtEnable, partBits, rangeSel, encryptEn, secLock};
  endfunction

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  task automatic powerCycle(input logic batt);
    porN = 0;
    battOk = batt;
    repeat (4) @(negedge clk);
    porN = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic extPulse(input int len, input logic stop, output int seen, output logic endRst);
    seen = 0;
    extRstPin = 1;
    stopMode = stop;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      seen += int'(coreRst);
    end
    extRstPin = 0;
    stopMode = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      seen += int'(coreRst);
    end
    endRst = coreRst;
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    logic endRst;

    // R3: reset held during power-on and released on the third edge after porN
    repeat (3) @(negedge clk);
    check(coreRst == 1'b1, "R3 reset while porN low", coreRst, 1);
    porN = 1;
    @(negedge clk);
    check(coreRst == 1'b1, "R3 still held after first edge", coreRst, 1);
    @(negedge clk);
    check(coreRst == 1'b1, "R3 still held after second edge", coreRst, 1);
    @(negedge clk);
    check(coreRst == 1'b0, "R3 released after third edge", coreRst, 0);
    repeat (2) @(negedge clk);
    // R1: weak-battery defaults
    check(bankNow() == SAFE_BANK, "R1 weak-battery power-on defaults", bankNow(), SAFE_BANK);

    // R4 R7 R8: table of pin pulses
    foreach (VEC[k]) begin
      int len;
      logic stp, acc;
      len = int'(VEC[k][9:2]);
      stp = VEC[k][1];
      acc = VEC[k][0];
      extPulse(len, stp, seen, endRst);
      check((seen > 0) == acc, $sformatf("R4 pulse of %0d edges acceptance", len), seen, acc);
      if (acc && stp) begin
        check(endRst == 1'b1, "R8 stop-mode reset still held during delay", endRst, 1);
        repeat (120) @(negedge clk);
        check(coreRst == 1'b0, "R8 stop-mode reset released after delay", coreRst, 0);
      end else begin
        check(endRst == 1'b0, "R7 reset released after pin low", endRst, 0);
      end
      if (acc && !stp)
        check(seen >= len - 24, "R7 reset held while pin high", seen, len - 24);
      repeat (3) @(negedge clk);
    end
    // R6: no external reset touched the bits
    check(bankNow() == SAFE_BANK, "R6 bits unchanged by external resets", bankNow(), SAFE_BANK);

    // R5: split burst
    seen = 0;
    extRstPin = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); seen += int'(coreRst); end
    extRstPin = 0;
    @(negedge clk); seen += int'(coreRst);
    extRstPin = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); seen += int'(coreRst); end
    extRstPin = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); seen += int'(coreRst); end
    check(seen == 0, "R5 split burst causes no reset", seen, 0);

    // R9: watchdog hold length and flag
    seen = 0;
    wdtTimeout = 1;
    @(negedge clk); seen += int'(coreRst);
    wdtTimeout = 0;
    for (int i = 0; i < 39; i++) begin @(negedge clk); seen += int'(coreRst); end
    check(seen == 24, "R9 watchdog hold length", seen, 24);
    check(bankNow() == WDT_BANK, "R9 watchdog sets porFlag only", bankNow(), WDT_BANK);

    // R6: external reset keeps porFlag=1
    extPulse(30, 1'b0, seen, endRst);
    check(seen > 0, "R6 external reset accepted", seen, 1);
    check(bankNow() == WDT_BANK, "R6 external reset keeps bits", bankNow(), WDT_BANK);

    // R2: good battery retains bits
    powerCycle(1'b1);
    check(bankNow() == WDT_BANK, "R2 good-battery power-on retains bits", bankNow(), WDT_BANK);
    check(coreRst == 1'b0, "R3 released after good-battery power-on", coreRst, 0);

    // R1: weak battery reloads defaults
    powerCycle(1'b0);
    check(bankNow() == SAFE_BANK, "R1 weak-battery power-on reloads defaults", bankNow(), SAFE_BANK);

    // R10: watchdog timeout on the acceptance edge
    seen = 0;
    extRstPin = 1;
    for (int i = 0; i < 26; i++) begin @(negedge clk); seen += int'(coreRst); end
    wdtTimeout = 1;
    @(negedge clk); seen += int'(coreRst);
    wdtTimeout = 0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); seen += int'(coreRst); end
    extRstPin = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); seen += int'(coreRst); end
    check(porFlag == 1'b0, "R10 external wins, porFlag unchanged", porFlag, 0);
    check(seen > 0 && seen < 10, "R10 reset length follows pin", seen, 6);
    check(coreRst == 1'b0, "R10 reset released", coreRst, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule